// File: doc/BRIEF.md
# Two-Level DMA Issue Scheduler

This block decides, every clock cycle, which of a set of DMA channels may put its next bus transfer on the bus. Each channel presents a ready flag and a priority flag. The block answers in the same cycle with a one-hot grant, the granted channel's index and a grant-valid strobe. The pacing logic that produces the ready flags, the transfer datapath and the bus fabric sit outside this block. The priority flag only changes the order in which channels are issued. It has no bearing on any bus-level priority.

Scheduling proceeds in rounds. In a round, every ready priority channel is issued once, in rotating index order. After that, exactly one ready normal channel is issued, and that grant closes the round. Normal channels take turns through a rotating pointer of their own. A channel that is not ready takes no slot. When nothing urgent is waiting, a ready normal channel is granted immediately, so normal channels lose no throughput on an unsaturated scheduler. When only already-served priority channels are ready, a new round opens in the same cycle and no issue slot is wasted.

Top module: `dma_issue_sched`

## Requirements
- R1: At most one channel is granted per cycle. `grant_oh` is one-hot with the bit at position `grant_id` set when `grant_vld` is 1, and all zero when `grant_vld` is 0.
- R2: `grant_vld` is 1 in exactly those cycles in which at least one `chan_rdy` bit is 1. No ready pattern leaves an idle cycle, and a normal channel is granted at once when no priority channel is waiting.
- R3: A channel whose `chan_hipri` bit is 0 is never granted while some ready channel with `chan_hipri` = 1 has not yet been served in the current round.
- R4: Among eligible priority channels, the grant goes to the first ready one at or after the index just above the last granted priority channel, wrapping from NCH-1 to 0. Channels that are not ready are skipped. After reset this search starts at index 0.
- R5: Within a round, each priority channel is granted at most once.
- R6: A grant to a normal channel closes the round. In the next cycle, every ready priority channel is eligible again.
- R7: Among ready normal channels, the grant goes to the first one at or after the index just above the last granted normal channel, wrapping around. After reset this search starts at index 0.
- R8: When every ready priority channel has already been served in the round and no normal channel is ready, a new round opens in the same cycle. One of those priority channels is granted under the R4 rule.
- R9: After reset the block is in an empty round with both search pointers at 0. With no channel ready, `grant_vld` is 0 and `grant_oh` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_rdy | input | NCH | Per-channel request: the channel has a transfer ready to issue |
| chan_hipri | input | NCH | Per-channel priority flag, 1 for a priority channel |
| grant_oh | output | NCH | One-hot grant for this cycle |
| grant_id | output | IDW | Index of the granted channel |
| grant_vld | output | 1 | A grant is issued this cycle |

## Verification
The scheduler holds three pieces of hidden state: the set of priority channels served in the current round, and two rotating search pointers. A wrong served set shows up at the ports in the very cycle it is consulted. Either a priority channel is granted twice before a normal grant, or a normal channel is granted too early, or a restarting round fails to open. A wrong pointer shows up as the wrong grant index on the next grant of that class. The bench therefore compares grant index and valid against a behavioural model of the rounds on every cycle, under fixed saturated patterns and long random traffic.

// File: rtl/dis_pkg.sv
package dis_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HI   = 2'd1,
    SRC_LO   = 2'd2
  } grant_src_e;

  function automatic int id_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dis_rr_pick.sv
module dis_rr_pick #(
  parameter int NCH = 8,
  parameter int IDW = 3
) (
  input  logic [NCH-1:0] req_vec,
  input  logic [IDW-1:0] start_ptr,
  output logic           hit,
  output logic [IDW-1:0] hit_id,
  output logic [NCH-1:0] hit_oh
);

  always_comb begin
    hit    = 1'b0;
    hit_id = '0;
    hit_oh = '0;
    for (int k = 0; k < NCH; k++) begin
      int j;
      j = int'(start_ptr) + k;
      if (j >= NCH) j = j - NCH;
      if (!hit && req_vec[j]) begin
        hit       = 1'b1;
        hit_id    = IDW'(j);
        hit_oh[j] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dis_ptr_reg.sv
module dis_ptr_reg #(
  parameter int NCH = 8,
  parameter int IDW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic [IDW-1:0] sel_id,
  output logic [IDW-1:0] ptr_q
);

  logic [IDW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      if (sel_id == IDW'(NCH - 1)) ptr_d = '0;
      else                         ptr_d = sel_id + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  // R4 R7
  ptr_moves_past_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && NCH > 1) |=> (ptr_q != $past(sel_id)));

endmodule

// File: rtl/dis_round_ctl.sv
module dis_round_ctl #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rdy_hi,
  input  logic           lo_any,
  input  logic           gnt_hi,
  input  logic           gnt_lo,
  input  logic [NCH-1:0] gnt_oh,
  output logic [NCH-1:0] hi_elig,
  output logic [NCH-1:0] served_q
);

  logic           restart;
  logic [NCH-1:0] served_eff;
  logic [NCH-1:0] served_d;
  logic           served_en;

  always_comb begin
    restart    = ((rdy_hi & ~served_q) == '0) && !lo_any;
    served_eff = restart ? '0 : served_q;
    hi_elig    = rdy_hi & ~served_eff;
  end

  always_comb begin
    served_en = gnt_hi || gnt_lo || restart;
    served_d  = served_eff;
    if (gnt_lo)      served_d = '0;
    else if (gnt_hi) served_d = served_eff | gnt_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         served_q <= '0;
    else if (served_en) served_q <= served_d;
  end

  // R6
  round_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_lo |=> (served_q == '0));

  // R5
  hi_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_hi |=> ((served_q & $past(gnt_oh)) == $past(gnt_oh)));

endmodule

// File: rtl/dma_issue_sched.sv
module dma_issue_sched #(
  parameter int NCH = 8,
  parameter int IDW = dis_pkg::id_width(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_rdy,
  input  logic [NCH-1:0] chan_hipri,
  output logic [NCH-1:0] grant_oh,
  output logic [IDW-1:0] grant_id,
  output logic           grant_vld
);
  import dis_pkg::*;

  logic [NCH-1:0] rdy_hi, rdy_lo, hi_elig, served_q;
  logic [NCH-1:0] hi_oh, lo_oh;
  logic [IDW-1:0] hi_id, lo_id, hp_ptr, lp_ptr;
  logic           hi_hit, lo_hit;
  grant_src_e     src;

  assign rdy_hi = chan_rdy & chan_hipri;
  assign rdy_lo = chan_rdy & ~chan_hipri;

  dis_round_ctl #(.NCH(NCH)) u_round (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy_hi   (rdy_hi),
    .lo_any   (|rdy_lo),
    .gnt_hi   (src == SRC_HI),
    .gnt_lo   (src == SRC_LO),
    .gnt_oh   (grant_oh),
    .hi_elig  (hi_elig),
    .served_q (served_q)
  );

  dis_rr_pick #(.NCH(NCH), .IDW(IDW)) u_pick_hi (
    .req_vec   (hi_elig),
    .start_ptr (hp_ptr),
    .hit       (hi_hit),
    .hit_id    (hi_id),
    .hit_oh    (hi_oh)
  );

  dis_rr_pick #(.NCH(NCH), .IDW(IDW)) u_pick_lo (
    .req_vec   (rdy_lo),
    .start_ptr (lp_ptr),
    .hit       (lo_hit),
    .hit_id    (lo_id),
    .hit_oh    (lo_oh)
  );

  always_comb begin
    if (hi_hit)      src = SRC_HI;
    else if (lo_hit) src = SRC_LO;
    else             src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_HI: begin grant_oh = hi_oh; grant_id = hi_id; grant_vld = 1'b1; end
      SRC_LO: begin grant_oh = lo_oh; grant_id = lo_id; grant_vld = 1'b1; end
      default: begin grant_oh = '0; grant_id = '0; grant_vld = 1'b0; end
    endcase
  end

  dis_ptr_reg #(.NCH(NCH), .IDW(IDW)) u_hp_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (src == SRC_HI),
    .sel_id (hi_id),
    .ptr_q  (hp_ptr)
  );

  dis_ptr_reg #(.NCH(NCH), .IDW(IDW)) u_lp_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (src == SRC_LO),
    .sel_id (lo_id),
    .ptr_q  (lp_ptr)
  );

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> ($onehot(grant_oh) && grant_oh[grant_id]));

  // R1
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld |-> (grant_oh == '0));

  // R2
  work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld == (|chan_rdy));

  // R3
  hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !chan_hipri[grant_id]) |-> ((rdy_hi & ~served_q) == '0));

endmodule

// File: tb/dma_issue_sched_bench.sv
module dma_issue_sched_bench;
  localparam int N   = 8;
  localparam int IDW = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   chan_rdy, chan_hipri;
  logic [N-1:0]   grant_oh;
  logic [IDW-1:0] grant_id;
  logic           grant_vld;

  int errors = 0;
  int checks = 0;

  bit m_served [N];
  int m_hp, m_lp;

  always #10 clk = ~clk;

  dma_issue_sched #(.NCH(N)) u_dma_issue_sched (
    .clk(clk), .rst_n(rst_n), .chan_rdy(chan_rdy), .chan_hipri(chan_hipri),
    .grant_oh(grant_oh), .grant_id(grant_id), .grant_vld(grant_vld)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_served[i] = 1'b0;
    m_hp = 0;
    m_lp = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    chan_rdy = '0;
    chan_hipri = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // Returns the granted id, or -1 for no grant, and advances the model state.
  function automatic int model_step(input logic [N-1:0] r, input logic [N-1:0] h);
    bit any_hi = 0, any_lo = 0;
    int got = -1;
    for (int i = 0; i < N; i++) begin
      if (r[i] && h[i] && !m_served[i]) any_hi = 1;
      if (r[i] && !h[i]) any_lo = 1;
    end
    if (!any_hi && !any_lo)
      for (int i = 0; i < N; i++) m_served[i] = 0;
    for (int k = 0; k < N && got < 0; k++) begin
      int c = (m_hp + k) % N;
      if (r[c] && h[c] && !m_served[c]) got = c;
    end
    if (got >= 0) begin
      m_served[got] = 1;
      m_hp = (got + 1) % N;
      return got;
    end
    for (int k = 0; k < N && got < 0; k++) begin
      int c = (m_lp + k) % N;
      if (r[c] && !h[c]) got = c;
    end
    if (got >= 0) begin
      m_lp = (got + 1) % N;
      for (int i = 0; i < N; i++) m_served[i] = 0;
    end
    return got;
  endfunction

  // One cycle: drive, compare with model at negedge, optional directed expectation.
  task automatic cycle(input logic [N-1:0] r, input logic [N-1:0] h,
                       input int exp_dir, input string tag);
    int m;
    chan_rdy = r;
    chan_hipri = h;
    @(negedge clk);
    m = model_step(r, h);
    check(grant_vld == (m >= 0), "R2 model grant_vld", int'(grant_vld), int'(m >= 0));
    if (m >= 0) begin
      check(int'(grant_id) == m, "R3/R4/R5/R7 model grant_id", int'(grant_id), m);
      check(grant_oh == (N'(1) << m), "R1 model grant_oh", int'(grant_oh), 1 << m);
    end else begin
      check(grant_oh == '0, "R1 idle grant_oh", int'(grant_oh), 0);
    end
    if (exp_dir != -2)
      check((grant_vld ? int'(grant_id) : -1) == exp_dir, tag,
            grant_vld ? int'(grant_id) : -1, exp_dir);
    @(posedge clk);
    #1;
  endtask

  initial begin
    int mix_seq [16] = '{1,4,6,0,1,4,6,3,1,4,6,5,1,4,6,0};
    do_reset();

    // R9: empty reset state, no grant
    cycle('0, '0, -1, "R9 no grant after reset");
    // R9 R7: pointer starts at 0, lowest ready normal channel wins
    cycle(8'b1111_1111, '0, 0, "R9 first normal grant at index 0");

    // R3 R4 R5 R6: saturated mix, priority {1,4,6}, normal {0,3,5}
    do_reset();
    for (int i = 0; i < 16; i++)
      cycle(8'b0111_1011, 8'b0101_0010, mix_seq[i], "R3/R4/R5/R6 mixed round order");

    // R8: priority-only traffic restarts rounds without idle cycles
    do_reset();
    for (int i = 0; i < 6; i++)
      cycle(8'b0010_0100, 8'b0010_0100, (i % 2 == 0) ? 2 : 5, "R8 round restart");

    // R7: normal-only rotation skipping non-ready channels
    do_reset();
    for (int i = 0; i < 6; i++)
      cycle(8'b0100_1000, '0, (i % 2 == 0) ? 3 : 6, "R7 normal rotation");

    // R2: normal channel served at once when no priority channel waits
    do_reset();
    cycle(8'b0000_0100, 8'b0000_0001, 2, "R2 immediate normal grant");
    cycle(8'b0000_0001, 8'b0000_0001, 0, "R2 priority alone");
    cycle('0, 8'b1111_1111, -1, "R2 idle with no ready channel");

    // R6: normal grant reopens the round for an already-served priority channel
    do_reset();
    cycle(8'b0000_0011, 8'b0000_0001, 0, "R6 priority first");
    cycle(8'b0000_0011, 8'b0000_0001, 1, "R5 served priority not regranted");
    cycle(8'b0000_0011, 8'b0000_0001, 0, "R6 round reopened");

    // Random traffic against the model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] r, h;
      r = N'($urandom);
      if ((i / 500) % 2 == 1) r = r & N'($urandom);
      h = N'($urandom);
      if ((i / 250) % 3 == 2) h = '1;
      cycle(r, h, -2, "");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule